// File: doc/BRIEF.md
# Serial EEPROM Page Write Controller

This block sits behind the bit-level engine of a two-wire serial EEPROM model. The engine reports four events: an address load that carries the start address of a write, each received data byte, a start condition and a stop condition. The controller places each byte in a one-page buffer and records which slots were filled. On a stop it runs a self-timed program cycle and then writes every filled slot of that page into the memory array in a single step.

The byte pointer advances only within the page. If more bytes arrive than a page holds, the pointer wraps to the first slot of the same page and the new bytes replace the earlier ones. While the program cycle runs, the block raises `busy` and ignores every event. The protocol engine uses `busy` to withhold the device-address acknowledge, which lets a master poll for completion. When the write-protect input is high, the controller refuses to commit to the upper part of the array. Reads are registered and are never blocked. They return the committed contents, including while a cycle is in progress.

Top module: `pgw_ctrl`

## Requirements
- R1: A write transaction of 1 to 32 bytes, addressed by `addr_load` and followed by bytes and `stop_cond`, commits all of its bytes in one program cycle, each at its own address.
- R2: Each accepted byte advances only the low 5 bits of `cur_addr`. The page bits `cur_addr[7:5]` stay fixed.
- R3: A byte that arrives after slot 31 of the page goes to slot 0 of the same page. Bytes that land on a slot already filled replace the earlier data, and the last one written to a slot is the one committed.
- R4: A `stop_cond` that follows at least one byte raises `busy` on the next clock edge. `busy` stays high for exactly CYCLE_TICKS cycles. The array keeps its old contents until `busy` falls, and holds the new bytes from then on.
- R5: While `busy` is high, `addr_load`, `byte_valid`, `start_cond` and `stop_cond` have no effect on `cur_addr`, on the memory or on `busy`.
- R6: When `wp` is high at commit and the page lies in the protected region, nothing is written. The protected region is the addresses whose top PROT_SHIFT bits are all 1, which is 0x80–0xFF by default. Pages outside that region, and any page when `wp` is low, are written normally.
- R7: `cur_addr` takes `addr_in` on an accepted address load. After each byte it points to the next address within the page, and it keeps that value through and after the commit.
- R8: Slots of the page that received no byte keep their previous memory contents.
- R9: A `start_cond` before `stop_cond` discards the buffer without a program cycle. A `stop_cond` with no byte received also starts no cycle.
- R10: After reset, `busy` is 0, `cur_addr` is 0 and every memory byte reads 0.
- R11: `rd_data` shows the byte at `rd_addr` one clock after `rd_addr` is applied. This holds whatever the value of `wp`, and also while `busy` is high, when it shows the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_load | input | 1 | Start-address event of a write transaction |
| addr_in | input | AW | Start address for `addr_load` |
| byte_valid | input | 1 | One received data byte |
| byte_in | input | 8 | Data byte for `byte_valid` |
| start_cond | input | 1 | Start condition seen on the bus |
| stop_cond | input | 1 | Stop condition seen on the bus |
| wp | input | 1 | Write-protect level |
| rd_addr | input | AW | Read address |
| busy | output | 1 | Program cycle in progress |
| cur_addr | output | AW | Current-address pointer |
| rd_data | output | 8 | Registered read data |

## Verification
Some internal faults only show up later. A wrong slot index or a stale valid flag appears as a wrong or unchanged byte when the page is read back after the cycle. A pointer that carries into the page bits shows on `cur_addr` one cycle after the byte. A timer that is off by one changes the width of `busy`, and the bench counts that width exactly. Events that leak through during the cycle appear as a moved `cur_addr`, an extra `busy` pulse or a changed byte as soon as the cycle ends.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {PG_IDLE, PG_FILL, PG_WAIT} pg_state_e;
  typedef logic [7:0] pg_byte_t;
endpackage

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int TICKS = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic run,
  output logic fire
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  logic [CW-1:0] cnt;

  assign fire = run && (cnt == CW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (run) begin
      if (fire) begin
        run <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (go) begin
      run <= 1'b1;
      cnt <= '0;
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < CW'(TICKS))); // R4
endmodule

// File: rtl/pgw_buffer.sv
module pgw_buffer #(
  parameter int PW = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        wr,
  input  logic [PW-1:0]               slot,
  input  pgw_pkg::pg_byte_t           din,
  output logic [(1<<PW)-1:0][7:0]     data,
  output logic [(1<<PW)-1:0]          valid
);
  localparam int SLOTS = 1 << PW;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid[i] <= 1'b0;
        data[i]  <= '0;
      end else if (clr) begin
        valid[i] <= 1'b0;
      end else if (wr && (slot == PW'(i))) begin
        valid[i] <= 1'b1;
        data[i]  <= din;
      end
    end
  end

  AST_SLOT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> valid[$past(slot)]); // R8
endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
  parameter int AW = 8,
  parameter int PW = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [(1<<PW)-1:0]          we,
  input  logic [AW-PW-1:0]            page,
  input  logic [(1<<PW)-1:0][7:0]     wdata,
  input  logic [AW-1:0]               rd_addr,
  output pgw_pkg::pg_byte_t           rd_data
);
  localparam int SLOTS = 1 << PW;
  localparam int DEPTH = 1 << AW;

  pgw_pkg::pg_byte_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++)
        if (we[i]) mem[{page, PW'(i)}] <= wdata[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl #(
  parameter int AW          = 8,
  parameter int PW          = 5,
  parameter int CYCLE_TICKS = 2_500_000,
  parameter int PROT_SHIFT  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          byte_valid,
  input  logic [7:0]    byte_in,
  input  logic          start_cond,
  input  logic          stop_cond,
  input  logic          wp,
  input  logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic [AW-1:0] cur_addr,
  output logic [7:0]    rd_data
);
  import pgw_pkg::*;
  localparam int SLOTS = 1 << PW;
  localparam int GW    = AW - PW;
  localparam int RLW   = $clog2(CYCLE_TICKS + 2);

  function automatic logic [AW-1:0] in_page_next(input logic [AW-1:0] a);
    return {a[AW-1:PW], a[PW-1:0] + 1'b1};
  endfunction

  function automatic logic page_locked(input logic [GW-1:0] pg, input logic wpv);
    return wpv && (&pg[GW-1 -: PROT_SHIFT]);
  endfunction

  pg_state_e             state;
  logic                  t_run, t_fire;
  logic [SLOTS-1:0][7:0] buf_data;
  logic [SLOTS-1:0]      buf_valid;
  logic [SLOTS-1:0]      commit_we;
  logic                  in_fill, ev_load, ev_byte, ev_go, locked;

  assign in_fill   = (state == PG_FILL);
  assign ev_go     = in_fill && stop_cond && (|buf_valid);
  assign ev_load   = addr_load && ((state == PG_IDLE) ||
                                   (in_fill && !stop_cond && !start_cond));
  assign ev_byte   = in_fill && byte_valid && !stop_cond && !start_cond && !addr_load;
  assign locked    = page_locked(cur_addr[AW-1:PW], wp);
  assign commit_we = t_fire ? (buf_valid & ~{SLOTS{locked}}) : '0;
  assign busy      = (state == PG_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PG_IDLE;
      cur_addr <= '0;
    end else begin
      unique case (state)
        PG_IDLE: if (addr_load) begin
          cur_addr <= addr_in;
          state    <= PG_FILL;
        end
        PG_FILL: begin
          if (stop_cond)       state    <= (|buf_valid) ? PG_WAIT : PG_IDLE;
          else if (start_cond) state    <= PG_IDLE;
          else if (addr_load)  cur_addr <= addr_in;
          else if (byte_valid) cur_addr <= in_page_next(cur_addr);
        end
        PG_WAIT: if (t_fire) state <= PG_IDLE;
        default: state <= PG_IDLE;
      endcase
    end
  end

  pgw_timer #(.TICKS(CYCLE_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(ev_go), .run(t_run), .fire(t_fire));

  pgw_buffer #(.PW(PW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(ev_load), .wr(ev_byte),
    .slot(cur_addr[PW-1:0]), .din(byte_in), .data(buf_data), .valid(buf_valid));

  pgw_array #(.AW(AW), .PW(PW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(commit_we), .page(cur_addr[AW-1:PW]),
    .wdata(buf_data), .rd_addr(rd_addr), .rd_data(rd_data));

  // Length of the current busy run, for the cycle-length check.
  logic [RLW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_addr)); // R5
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte |=> (cur_addr[AW-1:PW] == $past(cur_addr[AW-1:PW]))); // R2
  AST_FIRE_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    t_fire |-> busy); // R4
  AST_TIMER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    t_run == busy); // R4
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == RLW'(CYCLE_TICKS))); // R4
  AST_LOCK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (t_fire && locked) |-> (commit_we == '0)); // R6
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fill && stop_cond && (buf_valid == '0)) |=> !busy); // R9
endmodule

// File: tb/sim_pgw_ctrl.sv
`timescale 1ns/1ps
module sim_pgw_ctrl;
  localparam int TICKS = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load = 0, byte_valid = 0, start_cond = 0, stop_cond = 0, wp = 0;
  logic [7:0] addr_in = 0, byte_in = 0, rd_addr = 0;
  logic       busy;
  logic [7:0] cur_addr, rd_data;

  int checks = 0, errors = 0;
  logic [7:0] exp_mem [256];

  always #2 clk = ~clk;

  pgw_ctrl #(.AW(8), .PW(5), .CYCLE_TICKS(TICKS), .PROT_SHIFT(1)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_in(byte_in), .start_cond(start_cond),
    .stop_cond(stop_cond), .wp(wp), .rd_addr(rd_addr), .busy(busy),
    .cur_addr(cur_addr), .rd_data(rd_data));

  // {addr, count, seed[6:0], wp}
  localparam logic [23:0] VEC [7] = '{
    {8'h05, 8'd1,  7'h11, 1'b0},
    {8'h20, 8'd32, 7'h22, 1'b0},
    {8'h3C, 8'd8,  7'h33, 1'b0},
    {8'hA0, 8'd4,  7'h44, 1'b1},
    {8'h40, 8'd3,  7'h55, 1'b1},
    {8'hA2, 8'd2,  7'h66, 1'b0},
    {8'hE0, 8'd33, 7'h0B, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_load(input logic [7:0] a);
    @(negedge clk); addr_load = 1; addr_in = a;
    @(negedge clk); addr_load = 0;
  endtask
  task automatic pulse_byte(input logic [7:0] d);
    @(negedge clk); byte_valid = 1; byte_in = d;
    @(negedge clk); byte_valid = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_cond = 1;
    @(negedge clk); stop_cond = 0;
  endtask
  task automatic pulse_start();
    @(negedge clk); start_cond = 1;
    @(negedge clk); start_cond = 0;
  endtask

  task automatic read_chk(input logic [7:0] a, input string req);
    @(negedge clk); rd_addr = a;
    @(negedge clk);
    chk(req, rd_data, exp_mem[a]);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic page_write(input logic [7:0] a, input int cnt, input logic [6:0] seed,
                            input logic wpv);
    logic [7:0] sd [32];
    logic       sv [32];
    logic [7:0] p;
    int n;
    for (int i = 0; i < 32; i++) sv[i] = 0;
    p = a; wp = wpv;
    pulse_load(a);
    for (int k = 0; k < cnt; k++) begin
      logic [7:0] d;
      d = 8'(seed + k * 13);
      sd[p[4:0]] = d; sv[p[4:0]] = 1;
      pulse_byte(d);
      p = {p[7:5], p[4:0] + 5'd1};
    end
    chk("R2 R7 pointer after bytes", cur_addr, p);
    pulse_stop();
    chk("R4 busy raised", busy, 1);
    wait_idle(n);
    chk("R4 busy length", n, TICKS);
    chk("R7 pointer after commit", cur_addr, p);
    for (int i = 0; i < 32; i++)
      if (sv[i] && !(wpv && a[7])) exp_mem[{a[7:5], 5'(i)}] = sd[i];
    for (int i = 0; i < 32; i++)
      read_chk({a[7:5], 5'(i)}, "R1 R3 R6 R8 page contents");
    wp = 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 256; i++) exp_mem[i] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy at reset", busy, 0);
    chk("R10 cur_addr at reset", cur_addr, 0);
    rst_n = 1;
    read_chk(8'hFF, "R10 memory cleared");

    for (int v = 0; v < 7; v++)
      page_write(VEC[v][23:16], int'(VEC[v][15:8]), VEC[v][7:1], VEC[v][0]);

    // R9 start before stop discards
    pulse_load(8'h80); pulse_byte(8'h5A); pulse_byte(8'h5B);
    pulse_start();
    chk("R9 no cycle after start", busy, 0);
    chk("R7 pointer kept after abort", cur_addr, 8'h82);
    pulse_stop();
    chk("R9 stray stop no cycle", busy, 0);
    read_chk(8'h80, "R9 discarded byte");

    // R9 stop with no data
    pulse_load(8'h90); pulse_stop();
    chk("R9 empty stop no cycle", busy, 0);
    chk("R7 pointer equals load", cur_addr, 8'h90);

    // R5 / R11 / R4 events and reads during the cycle
    pulse_load(8'h10); pulse_byte(8'hC3); pulse_stop();
    chk("R4 busy after stop", busy, 1);
    read_chk(8'h10, "R4 R11 old data while busy");
    wp = 1;
    read_chk(8'hE1, "R11 read with wp high");
    wp = 0;
    pulse_load(8'h70); pulse_byte(8'hFF); pulse_start(); pulse_stop();
    wait_idle(n);
    chk("R5 pointer unaffected", cur_addr, 8'h11);
    @(negedge clk);
    chk("R5 no extra cycle", busy, 0);
    exp_mem[8'h10] = 8'hC3;
    read_chk(8'h10, "R4 new data after cycle");
    read_chk(8'h70, "R5 ignored byte not written");
    read_chk(8'h11, "R8 untouched slot");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule